// File: doc/BRIEF.md
# Dual-Port Lane-Write RAM

This block is a synchronous memory with two fully independent ports. Each port has its own clock, reset, enable, address, write data and lane write enables, and each can read or write in every cycle. A word is split into lanes of nine bits. Each lane holds eight data bits and one extra bit that is plain storage. Every write enable bit updates one whole lane.

Every access produces registered read data. A parameter per port sets what a write returns on that port's output. In write-first mode the output is the word as it stands after the write. In read-first mode it is the word as it stood before the write. In no-change mode the output keeps its last value. A second parameter per port adds an output register, which gives one more cycle of read latency. Reset clears only the output registers and never the stored words. At elaboration the array is preloaded with the arithmetic pattern given by two parameters.

Top module: `laneRamTdp`

## Requirements
- R1: With no extra output stage, a read with the enable high returns the stored word at the address on the port's output after the next rising edge of that port's clock.
- R2: In write-first mode, a write returns on the same port, one edge later, the word after the update. Lanes with their enable low show the old contents.
- R3: In read-first mode, a write returns on the same port the word as it was before the write.
- R4: In no-change mode, a write leaves the port's output unchanged. A later read returns the new word.
- R5: Write enable bit i updates only bits [9i+8:9i]. For example, the pattern 4'b1001 on a 36-bit word changes only bits [35:27] and [8:0].
- R6: The ninth bit of each lane (bit 9i+8) is stored and read back like any other bit, with no check or change.
- R7: With the enable low the port does not write, and its output holds.
- R8: A reset sampled at a rising edge clears both output registers of that port to zero, and the stored words are kept.
- R9: After elaboration, word i holds INIT_BASE + i*INIT_STEP, truncated to the word width.
- R10: With the extra output stage selected, read data appears one edge later than in R1. The output shows the previous value in the cycle between.
- R11: When both ports share one clock and write the same address in the same cycle, lanes enabled on port A take port A's data. Lanes enabled only on port B take port B's data.
- R12: A word written through one port is returned by a later read on the other port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkA | input | 1 | Port A clock |
| rstA | input | 1 | Port A synchronous reset of the output registers, active high |
| enA | input | 1 | Port A access enable |
| weA | input | LANES | Port A lane write enables |
| addrA | input | ADDR_W | Port A word address |
| wdataA | input | LANES*9 | Port A write data |
| rdataA | output | LANES*9 | Port A read data |
| clkB | input | 1 | Port B clock |
| rstB | input | 1 | Port B synchronous reset of the output registers, active high |
| enB | input | 1 | Port B access enable |
| weB | input | LANES | Port B lane write enables |
| addrB | input | ADDR_W | Port B word address |
| wdataB | input | LANES*9 | Port B write data |
| rdataB | output | LANES*9 | Port B read data |

## Verification
A wrong stored word stays hidden until some port reads that address. It then shows up on the output one edge after the read, or two edges later on a port with the extra stage. For this reason, every write is followed by a read, both on the same port and on the other one. A wrong output-register state shows at once. Examples are a capture in no-change mode, a reload while disabled, or a stale pipeline value after reset. Each shows at the first sampling point after the edge in question. The bank-combining logic is exercised by a same-address collision and by a lane pattern that touches only a ninth bit.

// File: rtl/laneRamPkg.sv
package laneRamPkg;

  localparam int LANE_BITS = 9;

  typedef enum logic [1:0] {
    RDW_WRITE_FIRST = 2'd0,
    RDW_READ_FIRST  = 2'd1,
    RDW_NO_CHANGE   = 2'd2
  } rdwMode_e;

  typedef struct packed {
    logic capture;   // load the first output register this edge
    logic takeNew;   // load the post-write word instead of the stored one
  } portStrobe_t;

endpackage

// File: rtl/laneRamCtrl.sv
module laneRamCtrl
  import laneRamPkg::*;
#(
  parameter int       LANES  = 4,
  parameter int       ADDR_W = 9,
  parameter rdwMode_e MODE_A = RDW_WRITE_FIRST,
  parameter rdwMode_e MODE_B = RDW_WRITE_FIRST
) (
  input  logic              enA,
  input  logic [LANES-1:0]  weA,
  input  logic [ADDR_W-1:0] addrA,
  input  logic              enB,
  input  logic [LANES-1:0]  weB,
  input  logic [ADDR_W-1:0] addrB,
  output portStrobe_t       strobeA,
  output portStrobe_t       strobeB,
  output logic [LANES-1:0]  laneWrA,
  output logic [LANES-1:0]  laneWrB
);

  logic writingA;
  logic writingB;
  logic sameAddr;
  logic [LANES-1:0] claimedByA;

  assign writingA = enA && (|weA);
  assign writingB = enB && (|weB);
  assign sameAddr = (addrA == addrB);

  // Lanes that port A writes this cycle at port B's address belong to A.
  assign claimedByA = enA ? (weA & {LANES{sameAddr}}) : '0;

  assign laneWrA = enA ? weA : '0;
  assign laneWrB = enB ? (weB & ~claimedByA) : '0;

  always_comb begin
    strobeA.capture = enA && !(writingA && (MODE_A == RDW_NO_CHANGE));
    strobeA.takeNew = (MODE_A == RDW_WRITE_FIRST);
    strobeB.capture = enB && !(writingB && (MODE_B == RDW_NO_CHANGE));
    strobeB.takeNew = (MODE_B == RDW_WRITE_FIRST);
  end

endmodule

// File: rtl/laneRamOutStage.sv
module laneRamOutStage
  import laneRamPkg::*;
#(
  parameter int WIDTH = 36,
  parameter bit PIPE  = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  portStrobe_t      strobe,
  input  logic [WIDTH-1:0] storedWord,
  input  logic [WIDTH-1:0] mergedWord,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] firstReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      firstReg <= '0;
    end else if (strobe.capture) begin
      firstReg <= strobe.takeNew ? mergedWord : storedWord;
    end
  end

  generate
    if (PIPE) begin : g_pipe
      logic [WIDTH-1:0] secondReg;
      always_ff @(posedge clk) begin
        if (rst) secondReg <= '0;
        else     secondReg <= firstReg;
      end
      assign rdata = secondReg;
    end else begin : g_direct
      assign rdata = firstReg;
    end
  endgenerate

endmodule

// File: rtl/laneRamData.sv
module laneRamData
  import laneRamPkg::*;
#(
  parameter int DEPTH  = 512,
  parameter int LANES  = 4,
  parameter int ADDR_W = 9,
  parameter bit PIPE_A = 1'b0,
  parameter bit PIPE_B = 1'b0,
  parameter logic [LANES*LANE_BITS-1:0] INIT_BASE = '0,
  parameter logic [LANES*LANE_BITS-1:0] INIT_STEP = '0
) (
  input  logic                         clkA,
  input  logic                         rstA,
  input  logic [ADDR_W-1:0]            addrA,
  input  logic [LANES*LANE_BITS-1:0]   wdataA,
  input  logic [LANES-1:0]             laneWrA,
  input  portStrobe_t                  strobeA,
  output logic [LANES*LANE_BITS-1:0]   rdataA,
  input  logic                         clkB,
  input  logic                         rstB,
  input  logic [ADDR_W-1:0]            addrB,
  input  logic [LANES*LANE_BITS-1:0]   wdataB,
  input  logic [LANES-1:0]             laneWrB,
  input  portStrobe_t                  strobeB,
  output logic [LANES*LANE_BITS-1:0]   rdataB
);

  localparam int WIDTH = LANES * LANE_BITS;

  // Each bank is written by one clock only; a word is the XOR of both banks.
  logic [WIDTH-1:0] bankA [DEPTH];
  logic [WIDTH-1:0] bankB [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      bankA[i] = INIT_BASE + WIDTH'(i) * INIT_STEP;
      bankB[i] = '0;
    end
  end

  logic [WIDTH-1:0] storedA, storedB;
  logic [WIDTH-1:0] partnerA, partnerB;
  logic [WIDTH-1:0] mergedA, mergedB;

  assign partnerA = bankB[addrA];
  assign partnerB = bankA[addrB];
  assign storedA  = bankA[addrA] ^ partnerA;
  assign storedB  = bankB[addrB] ^ partnerB;

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign mergedA[l*LANE_BITS +: LANE_BITS] =
        laneWrA[l] ? wdataA[l*LANE_BITS +: LANE_BITS] : storedA[l*LANE_BITS +: LANE_BITS];
      assign mergedB[l*LANE_BITS +: LANE_BITS] =
        laneWrB[l] ? wdataB[l*LANE_BITS +: LANE_BITS] : storedB[l*LANE_BITS +: LANE_BITS];
    end
  endgenerate

  always_ff @(posedge clkA) begin
    for (int l = 0; l < LANES; l++) begin
      if (laneWrA[l]) begin
        bankA[addrA][l*LANE_BITS +: LANE_BITS] <=
          wdataA[l*LANE_BITS +: LANE_BITS] ^ partnerA[l*LANE_BITS +: LANE_BITS];
      end
    end
  end

  always_ff @(posedge clkB) begin
    for (int l = 0; l < LANES; l++) begin
      if (laneWrB[l]) begin
        bankB[addrB][l*LANE_BITS +: LANE_BITS] <=
          wdataB[l*LANE_BITS +: LANE_BITS] ^ partnerB[l*LANE_BITS +: LANE_BITS];
      end
    end
  end

  laneRamOutStage #(.WIDTH(WIDTH), .PIPE(PIPE_A)) outA (
    .clk        (clkA),
    .rst        (rstA),
    .strobe     (strobeA),
    .storedWord (storedA),
    .mergedWord (mergedA),
    .rdata      (rdataA)
  );

  laneRamOutStage #(.WIDTH(WIDTH), .PIPE(PIPE_B)) outB (
    .clk        (clkB),
    .rst        (rstB),
    .strobe     (strobeB),
    .storedWord (storedB),
    .mergedWord (mergedB),
    .rdata      (rdataB)
  );

endmodule

// File: rtl/laneRamTdp.sv
module laneRamTdp
  import laneRamPkg::*;
#(
  parameter int       DEPTH  = 512,
  parameter int       LANES  = 4,
  parameter rdwMode_e MODE_A = RDW_WRITE_FIRST,
  parameter rdwMode_e MODE_B = RDW_WRITE_FIRST,
  parameter bit       PIPE_A = 1'b0,
  parameter bit       PIPE_B = 1'b0,
  parameter logic [LANES*LANE_BITS-1:0] INIT_BASE = '0,
  parameter logic [LANES*LANE_BITS-1:0] INIT_STEP = '0,
  localparam int      ADDR_W = $clog2(DEPTH),
  localparam int      WIDTH  = LANES * LANE_BITS
) (
  input  logic              clkA,
  input  logic              rstA,
  input  logic              enA,
  input  logic [LANES-1:0]  weA,
  input  logic [ADDR_W-1:0] addrA,
  input  logic [WIDTH-1:0]  wdataA,
  output logic [WIDTH-1:0]  rdataA,
  input  logic              clkB,
  input  logic              rstB,
  input  logic              enB,
  input  logic [LANES-1:0]  weB,
  input  logic [ADDR_W-1:0] addrB,
  input  logic [WIDTH-1:0]  wdataB,
  output logic [WIDTH-1:0]  rdataB
);

  portStrobe_t      strobeA, strobeB;
  logic [LANES-1:0] laneWrA, laneWrB;

  laneRamCtrl #(
    .LANES(LANES), .ADDR_W(ADDR_W), .MODE_A(MODE_A), .MODE_B(MODE_B)
  ) ctrl (
    .enA(enA), .weA(weA), .addrA(addrA),
    .enB(enB), .weB(weB), .addrB(addrB),
    .strobeA(strobeA), .strobeB(strobeB),
    .laneWrA(laneWrA), .laneWrB(laneWrB)
  );

  laneRamData #(
    .DEPTH(DEPTH), .LANES(LANES), .ADDR_W(ADDR_W),
    .PIPE_A(PIPE_A), .PIPE_B(PIPE_B),
    .INIT_BASE(INIT_BASE), .INIT_STEP(INIT_STEP)
  ) data (
    .clkA(clkA), .rstA(rstA), .addrA(addrA), .wdataA(wdataA),
    .laneWrA(laneWrA), .strobeA(strobeA), .rdataA(rdataA),
    .clkB(clkB), .rstB(rstB), .addrB(addrB), .wdataB(wdataB),
    .laneWrB(laneWrB), .strobeB(strobeB), .rdataB(rdataB)
  );

endmodule

// File: rtl/laneRamTdpChecker.sv
module laneRamTdpChecker
  import laneRamPkg::*;
#(
  parameter int       LANES  = 4,
  parameter rdwMode_e MODE_A = RDW_WRITE_FIRST,
  parameter rdwMode_e MODE_B = RDW_WRITE_FIRST,
  parameter bit       PIPE_A = 1'b0,
  parameter bit       PIPE_B = 1'b0,
  localparam int      WIDTH  = LANES * LANE_BITS
) (
  input logic             clkA,
  input logic             rstA,
  input logic             enA,
  input logic [LANES-1:0] weA,
  input logic [WIDTH-1:0] wdataA,
  input logic [WIDTH-1:0] rdataA,
  input logic             clkB,
  input logic             rstB,
  input logic             enB,
  input logic [LANES-1:0] weB,
  input logic [WIDTH-1:0] wdataB,
  input logic [WIDTH-1:0] rdataB
);

  logic rstTookA = 1'b0;
  logic rstTookB = 1'b0;

  always @(posedge clkA) rstTookA <= rstA;
  always @(posedge clkB) rstTookB <= rstB;

  always @(negedge clkA) begin
    if (rstTookA) begin
      AST_RESET_ZERO_A: assert (rdataA == '0); // R8
    end
  end

  always @(negedge clkB) begin
    if (rstTookB) begin
      AST_RESET_ZERO_B: assert (rdataB == '0); // R8
    end
  end

  generate
    if (!PIPE_A) begin : g_chkA
      AST_IDLE_HOLD_A: assert property (@(posedge clkA) disable iff (rstA)
        !enA |=> $stable(rdataA)); // R7
      if (MODE_A == RDW_WRITE_FIRST) begin : g_wf
        AST_FULL_WRITE_ECHO_A: assert property (@(posedge clkA) disable iff (rstA)
          (enA && (&weA)) |=> (rdataA == $past(wdataA))); // R2
      end
      if (MODE_A == RDW_NO_CHANGE) begin : g_nc
        AST_WRITE_HOLD_A: assert property (@(posedge clkA) disable iff (rstA)
          (enA && (|weA)) |=> $stable(rdataA)); // R4
      end
    end
    if (!PIPE_B) begin : g_chkB
      AST_IDLE_HOLD_B: assert property (@(posedge clkB) disable iff (rstB)
        !enB |=> $stable(rdataB)); // R7
      if (MODE_B == RDW_WRITE_FIRST) begin : g_wf
        AST_FULL_WRITE_ECHO_B: assert property (@(posedge clkB) disable iff (rstB)
          (enB && (&weB)) |=> (rdataB == $past(wdataB))); // R2
      end
      if (MODE_B == RDW_NO_CHANGE) begin : g_nc
        AST_WRITE_HOLD_B: assert property (@(posedge clkB) disable iff (rstB)
          (enB && (|weB)) |=> $stable(rdataB)); // R4
      end
    end
  endgenerate

endmodule

bind laneRamTdp laneRamTdpChecker #(
  .LANES(LANES), .MODE_A(MODE_A), .MODE_B(MODE_B), .PIPE_A(PIPE_A), .PIPE_B(PIPE_B)
) chk (
  .clkA(clkA), .rstA(rstA), .enA(enA), .weA(weA), .wdataA(wdataA), .rdataA(rdataA),
  .clkB(clkB), .rstB(rstB), .enB(enB), .weB(weB), .wdataB(wdataB), .rdataB(rdataB)
);

// File: tb/laneRamTdp_test.sv
module laneRamTdp_test;
  import laneRamPkg::*;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Instance one: port A write-first direct, port B read-first with extra stage.
  logic        enA = 0, enB = 0;
  logic [3:0]  weA = 0, weB = 0;
  logic [8:0]  addrA = 0, addrB = 0;
  logic [35:0] wdataA = 0, wdataB = 0;
  logic [35:0] rdataA, rdataB;

  laneRamTdp #(
    .DEPTH(512), .LANES(4), .MODE_A(RDW_WRITE_FIRST), .MODE_B(RDW_READ_FIRST),
    .PIPE_A(1'b0), .PIPE_B(1'b1), .INIT_BASE(36'h0), .INIT_STEP(36'h1)
  ) uut (
    .clkA(clk), .rstA(rst), .enA(enA), .weA(weA), .addrA(addrA), .wdataA(wdataA), .rdataA(rdataA),
    .clkB(clk), .rstB(rst), .enB(enB), .weB(weB), .addrB(addrB), .wdataB(wdataB), .rdataB(rdataB)
  );

  // Instance two: port A no-change, port B write-first, small depth.
  logic        enA2 = 0, enB2 = 0;
  logic [3:0]  weA2 = 0, weB2 = 0;
  logic [3:0]  addrA2 = 0, addrB2 = 0;
  logic [35:0] wdataA2 = 0, wdataB2 = 0;
  logic [35:0] rdataA2, rdataB2;

  laneRamTdp #(
    .DEPTH(16), .LANES(4), .MODE_A(RDW_NO_CHANGE), .MODE_B(RDW_WRITE_FIRST),
    .PIPE_A(1'b0), .PIPE_B(1'b0), .INIT_BASE(36'h0), .INIT_STEP(36'h1)
  ) uut2 (
    .clkA(clk), .rstA(rst), .enA(enA2), .weA(weA2), .addrA(addrA2), .wdataA(wdataA2), .rdataA(rdataA2),
    .clkB(clk), .rstB(rst), .enB(enB2), .weB(weB2), .addrB(addrB2), .wdataB(wdataB2), .rdataB(rdataB2)
  );

  typedef struct packed {
    logic        en;
    logic [3:0]  we;
    logic [8:0]  addr;
    logic [35:0] data;
    logic [35:0] expVal;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 4'b0000, 9'd5,   36'h000000000, 36'h000000005}, // R1 R9 read of preload
    '{1'b1, 4'b1111, 9'd5,   36'hABCDE1234, 36'hABCDE1234}, // R2 full write echoes
    '{1'b1, 4'b0000, 9'd5,   36'h000000000, 36'hABCDE1234}, // R1 read back
    '{1'b1, 4'b1001, 9'd5,   36'hFFFFFFFFF, 36'hFFCDE13FF}, // R5 R2 lanes 3 and 0 only
    '{1'b1, 4'b0000, 9'd5,   36'h000000000, 36'hFFCDE13FF}, // R5 read back
    '{1'b0, 4'b1111, 9'd5,   36'h000000000, 36'hFFCDE13FF}, // R7 disabled write, output holds
    '{1'b1, 4'b0000, 9'd5,   36'h000000000, 36'hFFCDE13FF}, // R7 nothing was written
    '{1'b1, 4'b0100, 9'd9,   36'h004000000, 36'h004000009}, // R6 lane 2 ninth bit only
    '{1'b1, 4'b0000, 9'd9,   36'h000000000, 36'h004000009}, // R6 ninth bit read back
    '{1'b1, 4'b0000, 9'd511, 36'h000000000, 36'h0000001FF}  // R9 last preloaded word
  };

  int compared   = 0;
  int mismatched = 0;
  bit done       = 0;

  task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [35:0] mergeLanes(input logic [35:0] old, input logic [35:0] nw,
                                             input logic [3:0] we);
    logic [35:0] r = old;
    for (int l = 0; l < 4; l++) if (we[l]) r[l*9 +: 9] = nw[l*9 +: 9];
    return r;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [35:0] expCol;
    repeat (2) @(negedge clk);
    check("R8 reset A", rdataA, 36'h0);
    check("R8 reset B", rdataB, 36'h0);
    check("R8 reset A2", rdataA2, 36'h0);
    check("R8 reset B2", rdataB2, 36'h0);
    rst = 0;

    for (int i = 0; i < NVEC; i++) begin
      enA = VECS[i].en; weA = VECS[i].we; addrA = VECS[i].addr; wdataA = VECS[i].data;
      @(negedge clk);
      check($sformatf("table vector %0d", i), rdataA, VECS[i].expVal);
    end
    enA = 0; weA = 0;

    // R3 and R10: read-first write on the pipelined port
    enB = 1; weB = 4'hF; addrB = 9'd20; wdataB = 36'h123456789;
    @(negedge clk);
    check("R10 stage delay", rdataB, 36'h0);
    enB = 0; weB = 0;
    @(negedge clk);
    check("R3 old word", rdataB, 36'h000000014);
    enB = 1; addrB = 9'd20;
    @(negedge clk);
    enB = 0;
    @(negedge clk);
    check("R10 pipelined read", rdataB, 36'h123456789);
    enA = 1; weA = 0; addrA = 9'd20;
    @(negedge clk);
    check("R12 cross-port read", rdataA, 36'h123456789);

    // R11: same-address collision
    enA = 1; weA = 4'b1100; addrA = 9'd30; wdataA = 36'hAAAAAAAAA;
    enB = 1; weB = 4'b0110; addrB = 9'd30; wdataB = 36'h555555555;
    @(negedge clk);
    enB = 0; weB = 0; weA = 0;
    @(negedge clk);
    expCol = mergeLanes(mergeLanes(36'd30, 36'h555555555, 4'b0010), 36'hAAAAAAAAA, 4'b1100);
    check("R11 collision", rdataA, expCol);

    // R8: reset mid-run keeps the array
    enA = 0; rst = 1;
    @(negedge clk);
    check("R8 mid reset A", rdataA, 36'h0);
    check("R8 mid reset B", rdataB, 36'h0);
    rst = 0; enA = 1; addrA = 9'd5;
    @(negedge clk);
    check("R8 array kept", rdataA, 36'hFFCDE13FF);
    enA = 0;

    // R4: no-change port
    enA2 = 1; weA2 = 0; addrA2 = 4'd3;
    @(negedge clk);
    check("R4 read", rdataA2, 36'h3);
    weA2 = 4'hF; wdataA2 = 36'h123;
    @(negedge clk);
    check("R4 write holds", rdataA2, 36'h3);
    weA2 = 0;
    @(negedge clk);
    check("R4 read new", rdataA2, 36'h123);
    enA2 = 0;
    enB2 = 1; weB2 = 0; addrB2 = 4'd3;
    @(negedge clk);
    check("R12 other port", rdataB2, 36'h123);
    weB2 = 4'b0001; wdataB2 = 36'hFFFFFFFFF;
    @(negedge clk);
    check("R2 partial write-first", rdataB2, 36'h1FF);
    enB2 = 0; weB2 = 0;
    @(negedge clk);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule